// File: doc/BRIEF.md
# Character Pattern Fetch with Cursor

This block sits between the display data memory and the column shift register of a dot-matrix character display controller. Each cycle it takes a character code and a pixel row index and produces the five pixel bits of that row of the character cell. Codes whose upper nibble is zero are served from an internal 128 x 5 user pattern RAM. Every other code is passed out on a pattern ROM port, and the ROM's answer is taken back in the same cycle.

On top of the stored pattern the block draws the cursor effects for the cell that matches the address counter. The underline is merged into the last pattern row. During the on-phase of blink, the whole cell is lit. Both effects are suppressed while the address counter points into pattern RAM, and a display-off enable blanks everything. The host fills the user RAM through a separate write port addressed by the address counter. The result is registered, so the pixel output follows its inputs by one clock.

Top module: `char_pattern_fetch`

## Requirements
- R1: When char_code_i[7:4] is zero the pattern is user RAM word {char_code_i[3:0], row_i} (code bits form address bits 6..3, row bits form address bits 2..0).
- R2: For any other code, rom_code_o equals char_code_i and rom_row_o equals row_i in the same cycle, and the pattern is rom_data_i.
- R3: Pattern bit 4 drives pix_o[4], the leftmost pixel, down to bit 0 on pix_o[0]; a 1 is a lit pixel and no bit is reordered.
- R4: pix_o is registered: it shows the result for the inputs present at the previous rising clock edge, and it is 0 while rst_ni is low.
- R5: With wr_en_i high, wr_data_i is stored at user RAM word wr_addr_i on the rising edge. A fetch of the same word in that same cycle returns the previous contents.
- R6: With disp_en_i low, pix_o is 5'b00000 whatever the other inputs are.
- R7: With the cursor enable, cursor_match_i high, ac_in_uram_i low and row_i equal to 7, all five pixels are lit (the underline ORed into the pattern).
- R8: On rows 0 to 6 the cursor enable has no effect on pix_o.
- R9: With the blink enable, cursor_match_i, blink_phase_i high and ac_in_uram_i low, every row of the cell is 5'b11111. With blink_phase_i low the normal pattern, including any underline, is shown.
- R10: With ac_in_uram_i high, neither cursor nor blink changes pix_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_code_i | input | 8 | Character code to render |
| row_i | input | 3 | Pixel row within the cell, 7 is the cursor row |
| disp_en_i | input | 1 | Display enable |
| cursor_en_i | input | 1 | Underline cursor enable |
| blink_en_i | input | 1 | Blink enable |
| cursor_match_i | input | 1 | Cell position equals the address counter |
| blink_phase_i | input | 1 | Blink phase, 1 is the lit phase |
| ac_in_uram_i | input | 1 | Address counter points into user pattern RAM |
| wr_en_i | input | 1 | User RAM write strobe |
| wr_addr_i | input | 7 | User RAM write address (from the address counter) |
| wr_data_i | input | 5 | User RAM write data |
| rom_code_o | output | 8 | Code presented to the pattern ROM |
| rom_row_o | output | 3 | Row presented to the pattern ROM |
| rom_data_i | input | 5 | Pattern returned by the ROM |
| pix_o | output | 5 | Registered pixel row, bit 4 leftmost |

## Verification
Two collisions can fall in one cycle. The first is a host write landing on the same user RAM word that the display fetch is reading. The bench provokes it directly, and also in random traffic where the write address follows the fetch address, and it expects the old word. The second is the underline and the blink both active on row 7. There the blink phase decides, and the bench compares the result against its own model of the priority: blank first, then blink, then underline.

// File: rtl/char_pattern_fetch_pkg.sv
package char_pattern_fetch_pkg;
  typedef struct packed {
    logic disp;
    logic cursor;
    logic blink;
    logic match;
    logic phase;
    logic in_uram;
  } cell_ctrl_t;
endpackage

// File: rtl/cfetch_uram.sv
module cfetch_uram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // async read: a same-cycle write is seen only after the edge
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cfetch_src_sel.sv
module cfetch_src_sel #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned UIDX_W = 4,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned PIX_W  = 5
) (
  input  logic [CODE_W-1:0]       code_i,
  input  logic [ROW_W-1:0]        row_i,
  input  logic [PIX_W-1:0]        uram_data_i,
  input  logic [PIX_W-1:0]        rom_data_i,
  output logic [UIDX_W+ROW_W-1:0] uram_addr_o,
  output logic [CODE_W-1:0]       rom_code_o,
  output logic [ROW_W-1:0]        rom_row_o,
  output logic [PIX_W-1:0]        pat_o
);
  localparam int unsigned HI_W = CODE_W - UIDX_W;

  logic is_user;
  assign is_user     = (code_i[CODE_W-1:UIDX_W] == '0);
  assign uram_addr_o = {code_i[UIDX_W-1:0], row_i};
  assign rom_code_o  = code_i;
  assign rom_row_o   = row_i;
  assign pat_o       = is_user ? uram_data_i : rom_data_i;

  always_comb begin
    if (HI_W == 0) $display("cfetch_src_sel: no upper code bits");
  end
endmodule

// File: rtl/cfetch_overlay.sv
module cfetch_overlay
  import char_pattern_fetch_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned PIX_W = 5
) (
  input  cell_ctrl_t       ctrl_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [PIX_W-1:0] pat_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [ROW_W-1:0] CURSOR_ROW = {ROW_W{1'b1}};

  logic hit, blink_on, uline_on;
  assign hit      = ctrl_i.match & ~ctrl_i.in_uram;
  assign blink_on = hit & ctrl_i.blink & ctrl_i.phase;
  assign uline_on = hit & ctrl_i.cursor & (row_i == CURSOR_ROW);

  always_comb begin
    if (!ctrl_i.disp)  pix_o = '0;
    else if (blink_on) pix_o = '1;
    else if (uline_on) pix_o = pat_i | {PIX_W{1'b1}};
    else               pix_o = pat_i;
  end
endmodule

// File: rtl/char_pattern_fetch.sv
module char_pattern_fetch
  import char_pattern_fetch_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned UIDX_W = 4,
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned PIX_W  = 5,
  localparam int unsigned AW    = UIDX_W + ROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] char_code_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              disp_en_i,
  input  logic              cursor_en_i,
  input  logic              blink_en_i,
  input  logic              cursor_match_i,
  input  logic              blink_phase_i,
  input  logic              ac_in_uram_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  output logic [CODE_W-1:0] rom_code_o,
  output logic [ROW_W-1:0]  rom_row_o,
  input  logic [PIX_W-1:0]  rom_data_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [AW-1:0]    uram_addr;
  logic [PIX_W-1:0] uram_data, raw_pat, pix_d;
  cell_ctrl_t       ctrl;

  assign ctrl = '{disp: disp_en_i, cursor: cursor_en_i, blink: blink_en_i,
                  match: cursor_match_i, phase: blink_phase_i,
                  in_uram: ac_in_uram_i};

  cfetch_uram #(.AW(AW), .DW(PIX_W)) u_uram (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .waddr_i(wr_addr_i),
    .wdata_i(wr_data_i),
    .raddr_i(uram_addr),
    .rdata_o(uram_data)
  );

  cfetch_src_sel #(.CODE_W(CODE_W), .UIDX_W(UIDX_W), .ROW_W(ROW_W), .PIX_W(PIX_W)) u_sel (
    .code_i     (char_code_i),
    .row_i      (row_i),
    .uram_data_i(uram_data),
    .rom_data_i (rom_data_i),
    .uram_addr_o(uram_addr),
    .rom_code_o (rom_code_o),
    .rom_row_o  (rom_row_o),
    .pat_o      (raw_pat)
  );

  cfetch_overlay #(.ROW_W(ROW_W), .PIX_W(PIX_W)) u_ovl (
    .ctrl_i(ctrl),
    .row_i (row_i),
    .pat_i (raw_pat),
    .pix_o (pix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= pix_d;
  end

  assert_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && !disp_en_i) |-> pix_o == '0);

  assert_blink_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && disp_en_i && blink_en_i && cursor_match_i && blink_phase_i && !ac_in_uram_i)
    |-> pix_o == {PIX_W{1'b1}});

  assert_underline_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && disp_en_i && cursor_en_i && cursor_match_i && !ac_in_uram_i && (&row_i))
    |-> pix_o == {PIX_W{1'b1}});

  assert_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && disp_en_i && ac_in_uram_i) |-> pix_o == $past(raw_pat));

  assert_rows_plain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && disp_en_i && !(blink_en_i && blink_phase_i) && !(&row_i)) |-> pix_o == $past(raw_pat));
endmodule

// File: tb/char_pattern_fetch_test.sv
module char_pattern_fetch_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] code = '0;
  logic [2:0] row = '0;
  logic       disp = 0, cen = 0, ben = 0, match = 0, phase = 0, incg = 0;
  logic       we = 0;
  logic [6:0] waddr = '0;
  logic [4:0] wdata = '0;
  logic [7:0] rom_code;
  logic [2:0] rom_row;
  logic [4:0] rom_data;
  logic [4:0] pix;

  int n_checks = 0, n_fail = 0;
  logic [4:0] model [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] rom_fn(input logic [7:0] c, input logic [2:0] r);
    return c[4:0] ^ {r, 2'b01} ^ c[7:3];
  endfunction

  assign rom_data = rom_fn(rom_code, rom_row);

  char_pattern_fetch uut (
    .clk_i(clk), .rst_ni(rst_n), .char_code_i(code), .row_i(row),
    .disp_en_i(disp), .cursor_en_i(cen), .blink_en_i(ben),
    .cursor_match_i(match), .blink_phase_i(phase), .ac_in_uram_i(incg),
    .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata),
    .rom_code_o(rom_code), .rom_row_o(rom_row), .rom_data_i(rom_data),
    .pix_o(pix)
  );

  function automatic logic [4:0] expect_pix();
    logic [4:0] base;
    logic hit;
    if (!disp) return 5'b00000;
    base = (code[7:4] == 4'h0) ? model[{code[3:0], row}] : rom_fn(code, row);
    hit = match & ~incg;
    if (hit && ben && phase) return 5'b11111;
    if (hit && cen && row == 3'd7) return base | 5'b11111;
    return base;
  endfunction

  function automatic string tag_of();
    if (!disp) return "R6";
    if (incg && match) return "R10";
    if (match && ben && phase) return "R9";
    if (match && cen && row == 3'd7) return "R7";
    if (match && cen) return "R8";
    if (code[7:4] == 4'h0) return "R1";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // drive at negedge, registered result checked at the following negedge (R4)
  task automatic step_check(input string tag);
    logic [4:0] exp;
    exp = expect_pix();
    @(negedge clk);
    check(tag, pix, exp);
  endtask

  task automatic set_cell(input logic [7:0] c, input logic [2:0] r, input logic d,
                          input logic ce, input logic be, input logic m,
                          input logic p, input logic ic);
    code = c; row = r; disp = d; cen = ce; ben = be; match = m; phase = p; incg = ic;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    @(negedge clk);
    set_cell(8'h00, 3'd7, 1, 1, 1, 1, 1, 0);
    @(negedge clk);
    check("R4 reset", pix, 5'b00000);
    rst_n = 1'b1;

    // fill user RAM through the write port (R5)
    for (int a = 0; a < 128; a++) begin
      we = 1; waddr = 7'(a); wdata = 5'($urandom);
      model[a] = wdata;
      @(negedge clk);
    end
    we = 0;
    set_cell(8'h00, 3'd0, 1, 0, 0, 0, 0, 0);

    // R3 bit order: single left pixel and single right pixel
    we = 1; waddr = 7'h00; wdata = 5'b10000;
    @(negedge clk); model[0] = 5'b10000; we = 0;
    step_check("R3 left");
    we = 1; waddr = 7'h00; wdata = 5'b00001;
    @(negedge clk); model[0] = 5'b00001; we = 0;
    step_check("R3 right");

    // R1 address mapping: code 0x0B row 5 -> word 0x5D
    set_cell(8'h0B, 3'd5, 1, 0, 0, 0, 0, 0);
    step_check("R1 map");

    // R2 ROM port routing, same cycle
    set_cell(8'hA7, 3'd3, 1, 0, 0, 0, 0, 0);
    #1;
    n_checks++;
    if (rom_code !== 8'hA7 || rom_row !== 3'd3) begin
      n_fail++;
      $display("FAIL R2 port: got %h/%0d expected a7/3", rom_code, rom_row);
    end
    step_check("R2 rom");

    // R5 collision: write and fetch same word in one cycle -> old data
    set_cell(8'h03, 3'd2, 1, 0, 0, 0, 0, 0);
    we = 1; waddr = 7'h1A; wdata = ~model[7'h1A];
    step_check("R5 collide");
    model[7'h1A] = wdata; we = 0;
    step_check("R5 after");

    // R6 display off with everything else active
    set_cell(8'h41, 3'd7, 0, 1, 1, 1, 1, 0);
    step_check("R6 blank");

    // R7 underline on user pattern with zero data
    we = 1; waddr = 7'h27; wdata = 5'b00000;
    @(negedge clk); model[7'h27] = 5'b00000; we = 0;
    set_cell(8'h04, 3'd7, 1, 1, 0, 1, 0, 0);
    step_check("R7 underline");

    // R8 cursor on row 6: no effect
    set_cell(8'h04, 3'd6, 1, 1, 0, 1, 0, 0);
    step_check("R8 row6");

    // R9 blink on/off phases on row 2, and blink+cursor row 7 phase 0
    set_cell(8'h04, 3'd2, 1, 0, 1, 1, 1, 0);
    step_check("R9 on");
    set_cell(8'h04, 3'd2, 1, 0, 1, 1, 0, 0);
    step_check("R9 off");
    set_cell(8'h04, 3'd7, 1, 1, 1, 1, 0, 0);
    step_check("R9 off cursor");

    // R10 inhibit while address counter is in user RAM
    set_cell(8'h04, 3'd7, 1, 1, 1, 1, 1, 1);
    step_check("R10 inhibit");

    // random traffic, write address often aims at the fetched word
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] exp;
      string tg;
      set_cell(($urandom % 3 == 0) ? {4'h0, 4'($urandom)} : 8'($urandom),
               3'($urandom), ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), ($urandom % 4) == 0);
      we = 1'($urandom);
      waddr = ($urandom % 2) ? {code[3:0], row} : 7'($urandom);
      wdata = 5'($urandom);
      exp = expect_pix();
      tg = tag_of();
      if (we) model[waddr] = wdata;
      @(negedge clk);
      check(tg, pix, exp);
    end
    we = 0;

    // R4 reset clears registered output mid-run
    set_cell(8'h04, 3'd2, 1, 0, 1, 1, 1, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R4 async", pix, 5'b00000);

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule